// File: doc/BRIEF.md
# Multi-Mode Operand Address Unit

This unit resolves a single operand for a simple load/store processor. A 4-bit mode code chooses where the operand comes from. It can be a constant carried by the instruction, a register value, a word fetched from memory, or a branch target formed from the program counter. The caller pulses `start` while the unit is idle and presents the register read data, the sign-extended displacement, the absolute address field and the PC in that same cycle. The unit latches what it needs at that edge.

Modes that fetch a word drive a memory read port with a valid/ready request handshake. They then wait for a response strobe. The auto-increment and auto-decrement modes also return a register writeback: an enable, the register number and the new value. The memory-indirect mode chains two reads, and the word from the first read becomes the address of the second. Every operation ends with a one-cycle `done` pulse, and the result and any writeback are valid in that cycle.

Top module: `opnd_resolver`

## Requirements
- R1: Mode code 0 (immediate): `result` equals `immVal`, no memory request is made, and `done` is high in the cycle after the start edge.
- R2: Mode code 1 (register): `result` equals `baseVal`, no memory request is made, and `done` is high in the cycle after the start edge.
- R3: Mode code 2 (direct): one read is issued at `absAddr`, and `result` is the returned word.
- R4: Mode code 3 (register indirect): one read is issued at `baseVal`, and `result` is the returned word.
- R5: Mode code 4 (base plus offset): one read is issued at `baseVal + immVal` modulo 2^WIDTH, and `result` is the returned word.
- R6: Mode code 5 (PC-relative): `result` equals `pcVal + immVal` modulo 2^WIDTH, no memory request is made, and `done` is high in the cycle after the start edge.
- R7: Mode code 6 (post-increment): the read is issued at `baseVal`. At `done`, `wbEn` is 1, `wbIdx` equals `baseIdx`, and `wbVal` equals `baseVal + 1` with wrap.
- R8: Mode code 7 (pre-decrement): the read is issued at `baseVal - 1` with wrap. At `done`, `wbEn` is 1, `wbIdx` equals `baseIdx`, and `wbVal` is that same decremented value.
- R9: Mode code 8 (memory indirect): the first read is issued at `absAddr`, the second read is issued at the word returned by the first, and `result` is the word returned by the second read.
- R10: `memReqValid` and `memReqAddr` stay constant until `memReqReady` is sampled high. A response is only taken in a cycle after its request was accepted, and any `memRspValid` seen while a request is still unaccepted is ignored.
- R11: `done` is high for exactly one cycle per operation. `wbEn` is high only together with `done`, and only for codes 6 and 7. `busy` is high from the start edge until after `done`, and `start` has no effect while `busy` is high.
- R12: Codes 9 to 15 produce `done` with `modeErr` high in the cycle after the start edge, `result` 0, no memory request and no writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation; taken only while idle |
| mode | input | 4 | Operand mode code |
| baseVal | input | WIDTH | Read data of the named base register |
| baseIdx | input | IDX_W | Number of the base register, used for writeback |
| immVal | input | WIDTH | Sign-extended immediate or displacement |
| absAddr | input | WIDTH | Absolute address field of the instruction |
| pcVal | input | WIDTH | Current program counter |
| memReqValid | output | 1 | Read request valid |
| memReqAddr | output | WIDTH | Read request address |
| memReqReady | input | 1 | Memory accepts the request |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | WIDTH | Read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | WIDTH | Operand value or target address, valid with done |
| wbEn | output | 1 | Base register writeback enable, valid with done |
| wbIdx | output | IDX_W | Writeback register number |
| wbVal | output | WIDTH | Writeback value |
| modeErr | output | 1 | Unsupported mode code, valid with done |

## Verification
Each of the sixteen codes is run with distinct base, displacement, absolute and PC values. A wrong source selection therefore shows up as a wrong address or result, and not as a coincidental match. Edge operands are included: a base of all ones for post-increment, zero for pre-decrement, and displacements and PC values that overflow. These separate wrapping arithmetic from widened or saturating arithmetic. The memory model varies both the request acceptance delay and the response delay, and it raises a junk response strobe while a request is still waiting. This shows whether the unit holds its request and ignores early data. Starts that arrive while the unit is busy show whether a second operation could slip in.

// File: rtl/opnd_pkg.sv
package opnd_pkg;

  typedef enum logic [3:0] {
    MODE_IMM     = 4'd0,
    MODE_REG     = 4'd1,
    MODE_DIR     = 4'd2,
    MODE_IND     = 4'd3,
    MODE_BOFS    = 4'd4,
    MODE_PCREL   = 4'd5,
    MODE_POSTINC = 4'd6,
    MODE_PREDEC  = 4'd7,
    MODE_MIND    = 4'd8
  } opMode_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;       // latch operands and computed address at start
    logic takeData;   // final read data becomes the result
    logic chainAddr;  // first read data becomes the next address
  } dpStrobe_t;

  function automatic logic modeValid(input logic [3:0] m);
    return m <= 4'd8;
  endfunction

  function automatic logic modeUsesMem(input logic [3:0] m);
    return (m == MODE_DIR) || (m == MODE_IND) || (m == MODE_BOFS) ||
           (m == MODE_POSTINC) || (m == MODE_PREDEC) || (m == MODE_MIND);
  endfunction

  function automatic logic modeWritesBack(input logic [3:0] m);
    return (m == MODE_POSTINC) || (m == MODE_PREDEC);
  endfunction

endpackage

// File: rtl/opnd_ctrl.sv
module opnd_ctrl
  import opnd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [3:0] mode,
  input  logic       memReqReady,
  input  logic       memRspValid,
  output dpStrobe_t  strb,
  output logic       memReqValid,
  output logic       busy,
  output logic       done,
  output logic       wbEn,
  output logic       modeErr
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_FIN} state_e;

  state_e state;
  logic   chainPend;
  logic   wbQ;
  logic   errQ;

  always_comb begin
    strb = '0;
    strb.load = (state == S_IDLE) && start;
    if (state == S_WAIT && memRspValid) begin
      if (chainPend) strb.chainAddr = 1'b1;
      else           strb.takeData  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      chainPend <= 1'b0;
      wbQ       <= 1'b0;
      errQ      <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          wbQ       <= modeWritesBack(mode);
          errQ      <= !modeValid(mode);
          chainPend <= (mode == MODE_MIND);
          state     <= modeUsesMem(mode) ? S_REQ : S_FIN;
        end
        S_REQ:  if (memReqReady) state <= S_WAIT;
        S_WAIT: if (memRspValid) begin
          if (chainPend) begin
            chainPend <= 1'b0;
            state     <= S_REQ;
          end else begin
            state     <= S_FIN;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign memReqValid = (state == S_REQ);
  assign busy        = (state != S_IDLE);
  assign done        = (state == S_FIN);
  assign wbEn        = done && wbQ;
  assign modeErr     = done && errQ;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R11
  AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> done); // R11
  AST_BAD_MODE_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !modeValid(mode)) |=> (done && modeErr && !memReqValid && !wbEn)); // R12
  AST_IMM_NO_MEM: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && (mode == MODE_IMM)) |=> (done && !memReqValid)); // R1
  AST_PCREL_NO_MEM: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && (mode == MODE_PCREL)) |=> (done && !memReqValid)); // R6

endmodule

// File: rtl/opnd_dpath.sv
module opnd_dpath
  import opnd_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic [3:0]       mode,
  input  logic [WIDTH-1:0] baseVal,
  input  logic [IDX_W-1:0] baseIdx,
  input  logic [WIDTH-1:0] immVal,
  input  logic [WIDTH-1:0] absAddr,
  input  logic [WIDTH-1:0] pcVal,
  input  logic [WIDTH-1:0] memRspData,
  output logic [WIDTH-1:0] memReqAddr,
  output logic [WIDTH-1:0] result,
  output logic [IDX_W-1:0] wbIdx,
  output logic [WIDTH-1:0] wbVal
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] ofsSum;    // shared base+displacement adder
  logic [WIDTH-1:0] pcSum;
  logic [WIDTH-1:0] incVal;
  logic [WIDTH-1:0] decVal;
  logic [WIDTH-1:0] effAddr;
  logic [WIDTH-1:0] directRes;
  logic [WIDTH-1:0] newBase;

  logic [WIDTH-1:0] addrQ;
  logic [WIDTH-1:0] resQ;
  logic [WIDTH-1:0] wbValQ;
  logic [IDX_W-1:0] wbIdxQ;

  always_comb begin
    ofsSum = baseVal + immVal;
    pcSum  = pcVal + immVal;
    incVal = baseVal + ONE;
    decVal = baseVal - ONE;

    case (mode)
      MODE_DIR, MODE_MIND:     effAddr = absAddr;
      MODE_IND, MODE_POSTINC:  effAddr = baseVal;
      MODE_BOFS:               effAddr = ofsSum;
      MODE_PREDEC:             effAddr = decVal;
      default:                 effAddr = '0;
    endcase

    case (mode)
      MODE_IMM:   directRes = immVal;
      MODE_REG:   directRes = baseVal;
      MODE_PCREL: directRes = pcSum;
      default:    directRes = '0;
    endcase

    newBase = (mode == MODE_POSTINC) ? incVal : decVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      resQ   <= '0;
      wbValQ <= '0;
      wbIdxQ <= '0;
    end else begin
      if (strb.load) begin
        addrQ  <= effAddr;
        resQ   <= directRes;
        wbValQ <= newBase;
        wbIdxQ <= baseIdx;
      end
      if (strb.chainAddr) addrQ <= memRspData;
      if (strb.takeData)  resQ  <= memRspData;
    end
  end

  assign memReqAddr = addrQ;
  assign result     = resQ;
  assign wbVal      = wbValQ;
  assign wbIdx      = wbIdxQ;

endmodule

// File: rtl/opnd_resolver.sv
module opnd_resolver
  import opnd_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [3:0]       mode,
  input  logic [WIDTH-1:0] baseVal,
  input  logic [IDX_W-1:0] baseIdx,
  input  logic [WIDTH-1:0] immVal,
  input  logic [WIDTH-1:0] absAddr,
  input  logic [WIDTH-1:0] pcVal,
  output logic             memReqValid,
  output logic [WIDTH-1:0] memReqAddr,
  input  logic             memReqReady,
  input  logic             memRspValid,
  input  logic [WIDTH-1:0] memRspData,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] result,
  output logic             wbEn,
  output logic [IDX_W-1:0] wbIdx,
  output logic [WIDTH-1:0] wbVal,
  output logic             modeErr
);

  dpStrobe_t strb;

  opnd_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .mode        (mode),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .strb        (strb),
    .memReqValid (memReqValid),
    .busy        (busy),
    .done        (done),
    .wbEn        (wbEn),
    .modeErr     (modeErr)
  );

  opnd_dpath #(.WIDTH(WIDTH), .IDX_W(IDX_W)) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .mode       (mode),
    .baseVal    (baseVal),
    .baseIdx    (baseIdx),
    .immVal     (immVal),
    .absAddr    (absAddr),
    .pcVal      (pcVal),
    .memRspData (memRspData),
    .memReqAddr (memReqAddr),
    .result     (result),
    .wbIdx      (wbIdx),
    .wbVal      (wbVal)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr))); // R10
  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (done && start) |=> !busy); // R11

endmodule

// File: tb/tb_opnd_resolver.sv
`timescale 1ns/1ps
module tb_opnd_resolver;

  localparam int W  = 16;
  localparam int IW = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [3:0]    mode = '0;
  logic [W-1:0]  baseVal = '0, immVal = '0, absAddr = '0, pcVal = '0;
  logic [IW-1:0] baseIdx = '0;
  logic          memReqReady = 1'b0, memRspValid = 1'b0;
  logic [W-1:0]  memRspData = '0;
  logic          memReqValid, busy, done, wbEn, modeErr;
  logic [W-1:0]  memReqAddr, result, wbVal;
  logic [IW-1:0] wbIdx;

  opnd_resolver #(.WIDTH(W), .IDX_W(IW)) dut (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .baseVal(baseVal),
    .baseIdx(baseIdx), .immVal(immVal), .absAddr(absAddr), .pcVal(pcVal),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr), .memReqReady(memReqReady),
    .memRspValid(memRspValid), .memRspData(memRspData), .busy(busy), .done(done),
    .result(result), .wbEn(wbEn), .wbIdx(wbIdx), .wbVal(wbVal), .modeErr(modeErr)
  );

  always #2 clk = ~clk; // 250 MHz

  int vecs = 0;
  int errs = 0;
  int cycles = 0;

  // reference model state
  int            ph = 0;       // 0 idle, 1 request, 2 wait data, 3 done
  int            mMode = 0;
  bit            secondRd = 0;
  logic [W-1:0]  eAddr = '0, eRes = '0, eWbVal = '0;
  logic [IW-1:0] eWbIdx = '0;
  bit            eWb = 0, eErr = 0;

  // memory responder state
  int           reqWait = 0, rspWait = 0, hsCount = 0;
  bit           outstanding = 0, rspOut = 0;
  logic [W-1:0] rdAddr = '0;

  function automatic logic [W-1:0] memWord(input logic [W-1:0] a);
    return {a[7:0], a[15:8]} ^ 16'hA5C3;
  endfunction

  function automatic string tagFor(input int m);
    case (m)
      0: return "R1";  1: return "R2";  2: return "R3";  3: return "R4";
      4: return "R5";  5: return "R6";  6: return "R7";  7: return "R8";
      8: return "R9";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%h expected=%h at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      ph = 0; secondRd = 0;
    end else begin
      case (ph)
        0: if (start) begin
          mMode = int'(mode);
          secondRd = 0;
          eErr = (mMode > 8);
          eWb = (mMode == 6) || (mMode == 7);
          eWbIdx = baseIdx;
          eWbVal = (mMode == 6) ? baseVal + 16'd1 : baseVal - 16'd1;
          eRes = '0;
          case (mMode)
            0: eRes = immVal;
            1: eRes = baseVal;
            5: eRes = pcVal + immVal;
            2, 8: eAddr = absAddr;
            3, 6: eAddr = baseVal;
            4: eAddr = baseVal + immVal;
            7: eAddr = baseVal - 16'd1;
            default: ;
          endcase
          ph = (mMode inside {2, 3, 4, 6, 7, 8}) ? 1 : 3;
        end
        1: if (memReqReady) ph = 2;
        2: if (memRspValid) begin
          if (mMode == 8 && !secondRd) begin
            secondRd = 1; eAddr = memRspData; ph = 1;
          end else begin
            eRes = memRspData; ph = 3;
          end
        end
        default: ph = 0;
      endcase
    end
  end

  // compare every cycle, then drive the memory side
  always @(negedge clk) begin
    chk("R11", "done", W'(done), W'(ph == 3));
    chk("R11", "busy", W'(busy), W'(ph != 0));
    chk("R10", "memReqValid", W'(memReqValid), W'(ph == 1));
    if (ph == 1) chk(secondRd ? "R9" : tagFor(mMode), "memReqAddr", memReqAddr, eAddr);
    if (ph == 3) begin
      chk(tagFor(mMode), "result", result, eRes);
      chk("R11", "wbEn", W'(wbEn), W'(eWb));
      chk("R12", "modeErr", W'(modeErr), W'(eErr));
      if (eWb) begin
        chk(tagFor(mMode), "wbIdx", W'(wbIdx), W'(eWbIdx));
        chk(tagFor(mMode), "wbVal", wbVal, eWbVal);
      end
    end

    memRspValid = 1'b0;
    if (rspOut) begin rspOut = 0; outstanding = 0; end
    if (memReqReady) begin
      memReqReady = 1'b0;
      outstanding = 1;
      rspWait = (hsCount + 1) % 4;
      hsCount++;
    end else if (outstanding) begin
      if (rspWait == 0) begin
        memRspValid = 1'b1; memRspData = memWord(rdAddr); rspOut = 1;
      end else rspWait--;
    end else if (memReqValid) begin
      if (reqWait == 0) begin
        memReqReady = 1'b1; rdAddr = memReqAddr; reqWait = hsCount % 3;
      end else begin
        reqWait--;
        memRspValid = 1'b1; memRspData = 16'hDEAD; // junk before acceptance, R10
      end
    end
  end

  task automatic runOp(input logic [3:0] m, input logic [W-1:0] b, input logic [IW-1:0] bi,
                       input logic [W-1:0] im, input logic [W-1:0] ab, input logic [W-1:0] pc);
    @(negedge clk);
    start = 1'b1; mode = m; baseVal = b; baseIdx = bi; immVal = im; absAddr = ab; pcVal = pc;
    @(negedge clk);
    // a start while busy must be ignored (R11)
    mode = 4'd0; immVal = 16'h7777; baseVal = 16'h1111;
    @(negedge clk);
    start = 1'b0;
    while (ph != 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int m = 0; m < 16; m++)
      runOp(4'(m), 16'h3000 + 16'(m * 16'h0111), 5'(m + 3), 16'h0040 + 16'(m),
            16'h5000 + 16'(m * 16'h0203), 16'h8000 + 16'(m * 4));
    runOp(4'd6, 16'hFFFF, 5'd31, 16'h0, 16'h0, 16'h0);   // R7 wrap
    runOp(4'd7, 16'h0000, 5'd1, 16'h0, 16'h0, 16'h0);    // R8 wrap
    runOp(4'd4, 16'hFFF0, 5'd2, 16'h0020, 16'h0, 16'h0); // R5 wrap
    runOp(4'd4, 16'h0100, 5'd2, 16'hFFFC, 16'h0, 16'h0); // R5 negative displacement
    runOp(4'd5, 16'h0, 5'd0, 16'hFFF8, 16'h0, 16'h0004); // R6 negative wrap
    runOp(4'd0, 16'h0, 5'd0, 16'hFFFF, 16'h0, 16'h0);    // R1
    runOp(4'd1, 16'hABCD, 5'd9, 16'h0, 16'h0, 16'h0);    // R2
    for (int k = 0; k < 6; k++) begin
      runOp(4'd8, 16'h0, 5'd0, 16'h0, 16'h1234 + 16'(k * 16'h0321), 16'h0); // R9
      runOp(4'd3, 16'h4242 + 16'(k), 5'd4, 16'h0, 16'h0, 16'h0);            // R4 / R10
      runOp(4'd2, 16'h0, 5'd0, 16'h0, 16'h0F00 + 16'(k), 16'h0);            // R3
    end
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #400000;
    errs++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule